// File: doc/BRIEF.md
# Half-flash converter control sequencer

This block is the digital controller of an 8-bit two-step converter, seen from a parallel processor bus. It decides when a conversion starts, steps through the upper-nibble and lower-nibble phases on clock-counted timers, captures the two 4-bit comparator results into an output register, and drives the interrupt, ready and data-bus-enable signals. The comparator results come in on two nibble inputs from outside the block. This block does not model analog tracking or supply current.

Two bus protocols are available, and the mode input selects between them. In read-start mode (mode low), a falling read strobe with chip select low starts a conversion. The processor holds read low until the result is ready, and the ready status tells it when to continue. In write-start mode (mode high), a falling write strobe starts the conversion. When write goes high again the upper nibble is captured and the lower-nibble phase starts. The interrupt then marks when the complete byte can be read. After power-down is released, a wake-up delay runs and then a tracking interval, and only after both does the block accept a new conversion.

Top module: `hfadc_ctl`

## Requirements
- R1: During and right after reset: irq_n is 1, rdy_low is 0, bus_en is 0 and bus_dat is 0.
- R2: In read-start mode (mode_sel=0), a conversion starts on the clock edge that sees rd_n go from 1 to 0 while cs_n is 0. irq_n stays 1 until it drops to 0 exactly UPPER_CYC+LOWER_CYC edges later. While irq_n stays 0, the enabled bus value does not change.
- R3: In read-start mode, rdy_low becomes 1 on the edge that sees cs_n fall. It returns to 0 on the edge where the conversion ends (the same edge where irq_n falls), or on a cs_n rising edge.
- R4: In write-start mode (mode_sel=1), a conversion starts on the edge that sees wr_n fall while cs_n is 0. The upper nibble is captured on the edge that sees wr_n rise. irq_n falls LOWER_CYC edges after that edge.
- R5: irq_n returns to 1 on the edge after a rising cs_n or rd_n is seen. If that rising edge falls on the same clock edge as the end of a conversion, the end of conversion wins and irq_n goes to 0.
- R6: bus_en is 1 only while cs_n=0, rd_n=0, pdn=0 and the block is not in power-down or wake-up. While bus_en is 1, bus_dat carries the result register.
- R7: After the end of a conversion and after reset, the block tracks for TRACK_CYC edges. A start seen on any of these edges is ignored, and the first edge that can accept a start is TRACK_CYC+1 edges after the end of conversion. An ignored start leaves irq_n and the result unchanged.
- R8: While pdn is 1, a running conversion is abandoned and start requests are ignored. On the edge after pdn is seen, irq_n=1, rdy_low=0 and bus_en=0.
- R9: After pdn is first seen low, WAKE_CYC wake-up edges pass, then TRACK_CYC tracking edges. A start is accepted no earlier than the following edge.
- R10: In write-start mode rdy_low stays 0.
- R11: The result byte is {upper, lower}. In read-start mode, upper is the hi_nib value seen UPPER_CYC edges after the start edge. lower is the lo_nib value seen on the end-of-conversion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (write-start mode) |
| mode_sel | input | 1 | 0 selects read-start mode, 1 selects write-start mode |
| pdn | input | 1 | Power-down request, active high |
| hi_nib | input | 4 | Upper comparator nibble |
| lo_nib | input | 4 | Lower comparator nibble |
| bus_dat | output | 8 | Data bus value, 0 while not enabled |
| bus_en | output | 1 | Data bus drive enable (0 means released) |
| irq_n | output | 1 | End-of-conversion interrupt, active low |
| rdy_low | output | 1 | 1 while the open-drain ready line is pulled low |

## Verification
The interesting collision is an interrupt clear from a rising read strobe that lands on the same clock edge as the end of a conversion. The bench sets this up in write-start mode. It pulses rd_n low for one cycle and releases it so that the release is sampled on the lower phase's final edge. It then expects irq_n low, because completion wins. A later read pulse must still clear irq_n and show the byte captured in that conversion. The random nibble streams change every cycle, so the bench can check that each nibble was captured on exactly its edge.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

    // sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_UPPER  = 3'd1,
        SQ_LOWER  = 3'd2,
        SQ_WAITWR = 3'd3,
        SQ_PDN    = 3'd4,
        SQ_WAKE   = 3'd5
    } seq_st_e;

    // per-pin event bundle produced by the edge detector
    typedef struct packed {
        logic fall;
        logic rise;
        logic lvl;
    } pin_edge_t;

    localparam int PIN_CS = 0;
    localparam int PIN_RD = 1;
    localparam int PIN_WR = 2;
    localparam int NPINS  = 3;

endpackage

// File: rtl/hfadc_edges.sv
module hfadc_edges
    import hfadc_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        pins_n,
    output pin_edge_t [N-1:0]   ev
);

    logic [N-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = pins_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign ev[i].fall = lvl_q[i] & ~pins_n[i];
        assign ev[i].rise = ~lvl_q[i] & pins_n[i];
        assign ev[i].lvl  = pins_n[i];
    end

endmodule

// File: rtl/hfadc_core.sv
module hfadc_core
    import hfadc_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int TRACK_CYC = 4,
    parameter int UPPER_CYC = 4,
    parameter int LOWER_CYC = 4,
    parameter int WAKE_CYC  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_sel,
    input  logic                  pdn,
    input  pin_edge_t [NPINS-1:0] ev,
    input  logic [NIB_W-1:0]      hi_nib,
    input  logic [NIB_W-1:0]      lo_nib,
    output logic [2*NIB_W-1:0]    res_o,
    output logic                  irq_n_o,
    output logic                  rdy_low_o,
    output logic                  awake_o
);

    localparam int DW   = 2 * NIB_W;
    localparam int M1   = (TRACK_CYC > UPPER_CYC) ? TRACK_CYC : UPPER_CYC;
    localparam int M2   = (LOWER_CYC > WAKE_CYC) ? LOWER_CYC : WAKE_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    localparam logic [CW-1:0] UP_LAST  = CW'(UPPER_CYC - 1);
    localparam logic [CW-1:0] LO_LAST  = CW'(LOWER_CYC - 1);
    localparam logic [CW-1:0] WK_LAST  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] TRK_FULL = CW'(TRACK_CYC);

    typedef struct packed {
        seq_st_e        st;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  trk;
        logic [DW-1:0]  res;
        logic           irq_n;
        logic           rdy_low;
    } core_t;

    localparam core_t CORE_RST = '{
        st:      SQ_IDLE,
        cnt:     '0,
        trk:     '0,
        res:     '0,
        irq_n:   1'b1,
        rdy_low: 1'b0
    };

    core_t d, q;

    logic start_rd, start_wr, tracked, conv_done, awake;

    assign awake = (q.st == SQ_IDLE) || (q.st == SQ_UPPER) ||
                   (q.st == SQ_LOWER) || (q.st == SQ_WAITWR);

    always_comb begin
        d         = q;
        conv_done = 1'b0;
        start_rd  = ~mode_sel & ~ev[PIN_CS].lvl & ev[PIN_RD].fall;
        start_wr  =  mode_sel & ~ev[PIN_CS].lvl & ev[PIN_WR].fall;
        tracked   = (q.trk == TRK_FULL);

        // interrupt release on a strobe going high
        if (ev[PIN_CS].rise || ev[PIN_RD].rise) begin
            d.irq_n = 1'b1;
        end

        unique case (q.st)
            SQ_PDN: begin
                d.st  = SQ_WAKE;
                d.cnt = '0;
            end
            SQ_WAKE: begin
                if (q.cnt == WK_LAST) begin
                    d.st  = SQ_IDLE;
                    d.cnt = '0;
                    d.trk = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_IDLE: begin
                if (tracked && start_rd) begin
                    d.st    = SQ_UPPER;
                    d.cnt   = '0;
                    d.irq_n = 1'b1;
                end else if (tracked && start_wr) begin
                    d.st    = SQ_WAITWR;
                    d.cnt   = '0;
                    d.irq_n = 1'b1;
                end else if (!tracked) begin
                    d.trk = q.trk + 1'b1;
                end
            end
            SQ_UPPER: begin
                if (q.cnt == UP_LAST) begin
                    d.res[DW-1:NIB_W] = hi_nib;
                    d.st  = SQ_LOWER;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_WAITWR: begin
                if (ev[PIN_WR].rise) begin
                    d.res[DW-1:NIB_W] = hi_nib;
                    d.st  = SQ_LOWER;
                    d.cnt = '0;
                end
            end
            SQ_LOWER: begin
                if (q.cnt == LO_LAST) begin
                    d.res[NIB_W-1:0] = lo_nib;
                    d.st      = SQ_IDLE;
                    d.cnt     = '0;
                    d.trk     = '0;
                    d.irq_n   = 1'b0;
                    conv_done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st  = SQ_IDLE;
                d.cnt = '0;
            end
        endcase

        // ready status, read-start mode only
        if (!mode_sel && ev[PIN_CS].fall && awake) begin
            d.rdy_low = 1'b1;
        end
        if (conv_done || ev[PIN_CS].rise || mode_sel) begin
            d.rdy_low = 1'b0;
        end

        // power-down overrides everything
        if (pdn) begin
            d.st      = SQ_PDN;
            d.cnt     = '0;
            d.trk     = '0;
            d.irq_n   = 1'b1;
            d.rdy_low = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign res_o     = q.res;
    assign irq_n_o   = q.irq_n;
    assign rdy_low_o = q.rdy_low;
    assign awake_o   = awake;

endmodule

// File: rtl/hfadc_bus.sv
module hfadc_bus #(
    parameter int DW = 8
) (
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          pdn,
    input  logic          awake,
    input  logic [DW-1:0] res,
    output logic          bus_en,
    output logic [DW-1:0] bus_dat
);

    always_comb begin
        bus_en  = ~cs_n & ~rd_n & ~pdn & awake;
        bus_dat = bus_en ? res : '0;
    end

endmodule

// File: rtl/hfadc_ctl.sv
module hfadc_ctl
    import hfadc_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int TRACK_CYC = 4,
    parameter int UPPER_CYC = 4,
    parameter int LOWER_CYC = 4,
    parameter int WAKE_CYC  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               mode_sel,
    input  logic               pdn,
    input  logic [NIB_W-1:0]   hi_nib,
    input  logic [NIB_W-1:0]   lo_nib,
    output logic [2*NIB_W-1:0] bus_dat,
    output logic               bus_en,
    output logic               irq_n,
    output logic               rdy_low
);

    localparam int DW = 2 * NIB_W;

    logic [NPINS-1:0]      pins_n;
    pin_edge_t [NPINS-1:0] ev;
    logic [DW-1:0]         res;
    logic                  awake;

    always_comb begin
        pins_n         = '1;
        pins_n[PIN_CS] = cs_n;
        pins_n[PIN_RD] = rd_n;
        pins_n[PIN_WR] = wr_n;
    end

    hfadc_edges #(.N(NPINS)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_n (pins_n),
        .ev     (ev)
    );

    hfadc_core #(
        .NIB_W     (NIB_W),
        .TRACK_CYC (TRACK_CYC),
        .UPPER_CYC (UPPER_CYC),
        .LOWER_CYC (LOWER_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .pdn       (pdn),
        .ev        (ev),
        .hi_nib    (hi_nib),
        .lo_nib    (lo_nib),
        .res_o     (res),
        .irq_n_o   (irq_n),
        .rdy_low_o (rdy_low),
        .awake_o   (awake)
    );

    hfadc_bus #(.DW(DW)) u_bus (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .pdn     (pdn),
        .awake   (awake),
        .res     (res),
        .bus_en  (bus_en),
        .bus_dat (bus_dat)
    );

endmodule

// File: rtl/hfadc_chk.sv
module hfadc_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          mode_sel,
    input logic          pdn,
    input logic [DW-1:0] bus_dat,
    input logic          bus_en,
    input logic          irq_n,
    input logic          rdy_low
);

    // R6: enable only with both strobes low and no power-down
    p_bus_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> (!cs_n && !rd_n && !pdn));

    // R8: power-down forces idle outputs on the next cycle
    p_pdn_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (irq_n && !rdy_low && !bus_en));

    // R9: first cycle after release is still asleep
    p_wake_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pdn) |=> (!bus_en && irq_n));

    // R10: no ready pull in write-start mode
    p_no_rdy_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |=> !rdy_low);

    // R3: ready is released no later than the interrupt falls
    p_rdy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> !rdy_low);

    // R5: chip-select release clears the interrupt unless a completion coincides
    p_irq_cs_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (irq_n || $fell(irq_n)));

    // R2: the enabled result holds while the interrupt stays low
    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !irq_n && $past(bus_en && !irq_n)) |-> $stable(bus_dat));

endmodule

bind hfadc_ctl hfadc_chk #(.DW(2 * NIB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .mode_sel (mode_sel),
    .pdn      (pdn),
    .bus_dat  (bus_dat),
    .bus_en   (bus_en),
    .irq_n    (irq_n),
    .rdy_low  (rdy_low)
);

// File: tb/sim_hfadc_ctl.sv
`timescale 1ns/1ps
module sim_hfadc_ctl;

    localparam int T = 4;
    localparam int U = 4;
    localparam int L = 4;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, rd_n, wr_n, mode_sel, pdn;
    logic [3:0] hi_nib, lo_nib;
    logic [7:0] bus_dat;
    logic       bus_en, irq_n, rdy_low;

    int edges = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int d_last = 0;
    int unsigned salt;
    logic [7:0] last_byte = 8'h00;

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    hfadc_ctl #(.NIB_W(4), .TRACK_CYC(T), .UPPER_CYC(U), .LOWER_CYC(L),
                .WAKE_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .mode_sel(mode_sel), .pdn(pdn), .hi_nib(hi_nib), .lo_nib(lo_nib),
        .bus_dat(bus_dat), .bus_en(bus_en), .irq_n(irq_n), .rdy_low(rdy_low)
    );

    // nibble value driven after edge k, seen on edge k+1
    function automatic logic [3:0] hpat(input int k);
        return 4'((k * 13 + int'(salt)) ^ (k >> 2));
    endfunction
    function automatic logic [3:0] lpat(input int k);
        return 4'((k * 7 + int'(salt >> 4)) ^ (k >> 1) ^ 5);
    endfunction

    always @(negedge clk) begin
        hi_nib <= hpat(edges);
        lo_nib <= lpat(edges);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edges);
        end
    endtask

    task automatic wait_to(input int k);
        while (edges < k) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // read-start conversion, start on the first edge tracking allows
    task automatic read_conv;
        int s;
        logic [7:0] exp;
        cs_n = 1'b0;
        @(negedge clk);
        chk("R3 rdy after cs fall", rdy_low, 1);
        wait_to((edges > d_last + T) ? edges : d_last + T);
        rd_n = 1'b0;
        s = edges + 1;
        wait_to(s + U + L - 1);
        chk("R2 irq before end", irq_n, 1);
        chk("R3 rdy during conv", rdy_low, 1);
        @(negedge clk);
        exp = {hpat(s + U - 1), lpat(s + U + L - 1)};
        chk("R2 irq at end", irq_n, 0);
        chk("R3 rdy released", rdy_low, 0);
        chk("R6 bus enabled", bus_en, 1);
        chk("R11 result byte", bus_dat, exp);
        d_last = s + U + L;
        last_byte = exp;
        rd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 irq clear on rd rise", irq_n, 1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R6 bus released", bus_en, 0);
    endtask

    // write-start conversion; clr_cs clears the interrupt via cs instead of rd
    task automatic wr_conv(input int wlen, input bit clr_cs);
        int s, r;
        logic [7:0] exp;
        cs_n = 1'b0;
        wait_to((edges > d_last + T) ? edges : d_last + T);
        wr_n = 1'b0;
        s = edges + 1;
        wait_to(s + wlen - 1);
        wr_n = 1'b1;
        r = s + wlen;
        wait_to(r + L - 1);
        chk("R4 irq before end", irq_n, 1);
        chk("R10 no rdy in wr mode", rdy_low, 0);
        @(negedge clk);
        chk("R4 irq at end", irq_n, 0);
        exp = {hpat(r - 1), lpat(r + L - 1)};
        d_last = r + L;
        last_byte = exp;
        if (clr_cs) begin
            cs_n = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk("R5 irq clear on cs rise", irq_n, 1);
        end else begin
            rd_n = 1'b0;
            #1;
            chk("R6 bus enabled", bus_en, 1);
            chk("R4 result byte", bus_dat, exp);
            @(negedge clk);
            chk("R5 irq kept by rd fall", irq_n, 0);
            rd_n = 1'b1;
            @(negedge clk);
            chk("R5 irq clear on rd rise", irq_n, 1);
            cs_n = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int s, r, p;
        logic [7:0] exp;
        salt = $urandom(32'd5171);
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        mode_sel = 1'b0; pdn = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", irq_n, 1);
        rst_n = 1'b1;
        d_last = edges;
        chk("R1 irq", irq_n, 1);
        chk("R1 rdy", rdy_low, 0);
        chk("R1 bus_en", bus_en, 0);
        chk("R1 bus_dat", bus_dat, 0);
        rd_n = 1'b0;
        #1;
        chk("R6 no bus with cs high", bus_en, 0);
        rd_n = 1'b1;
        @(negedge clk);

        // first conversion at the exact tracking boundary after reset
        read_conv();

        // R7: a start on the last tracking edge is ignored
        cs_n = 1'b0;
        wait_to(d_last + T - 1);
        rd_n = 1'b0;
        repeat (U + L + 2) @(negedge clk);
        chk("R7 ignored start irq", irq_n, 1);
        chk("R7 ignored start bus_en", bus_en, 1);
        chk("R7 result unchanged", bus_dat, last_byte);
        rd_n = 1'b1;
        cs_n = 1'b1;
        @(negedge clk);
        read_conv();

        // R5 conflict: rd release sampled on the completion edge
        mode_sel = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        wait_to((edges > d_last + T) ? edges : d_last + T);
        wr_n = 1'b0;
        s = edges + 1;
        @(negedge clk);
        wr_n = 1'b1;
        r = s + 1;
        wait_to(r + L - 2);
        rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R5 completion wins over rd rise", irq_n, 0);
        exp = {hpat(r - 1), lpat(r + L - 1)};
        rd_n = 1'b0;
        #1;
        chk("R4 conflict result", bus_dat, exp);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 later rd clears", irq_n, 1);
        cs_n = 1'b1;
        d_last = r + L;
        last_byte = exp;
        @(negedge clk);

        wr_conv(3, 1'b1);

        // R8: power-down during the lower phase
        cs_n = 1'b0;
        wait_to((edges > d_last + T) ? edges : d_last + T);
        wr_n = 1'b0;
        s = edges + 1;
        @(negedge clk);
        wr_n = 1'b1;
        r = s + 1;
        wait_to(r + 1);
        pdn = 1'b1;
        @(negedge clk);
        chk("R8 irq idle", irq_n, 1);
        chk("R8 rdy idle", rdy_low, 0);
        rd_n = 1'b0;
        #1;
        chk("R8 bus off", bus_en, 0);
        repeat (L + 3) @(negedge clk);
        chk("R8 aborted no irq", irq_n, 1);
        rd_n = 1'b1;
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        pdn = 1'b0;
        p = edges;
        // R9: start one edge too early is ignored
        wait_to(p + W + T);
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (L + 3) @(negedge clk);
        chk("R9 early start ignored", irq_n, 1);
        rd_n = 1'b0;
        #1;
        chk("R8 partial result kept", bus_dat, {hpat(r - 1), last_byte[3:0]});
        @(negedge clk);
        rd_n = 1'b1;
        pdn = 1'b1;
        repeat (3) @(negedge clk);
        pdn = 1'b0;
        p = edges;
        wait_to(p + W + T + 1);
        wr_n = 1'b0;
        s = edges + 1;
        @(negedge clk);
        wr_n = 1'b1;
        r = s + 1;
        wait_to(r + L - 1);
        chk("R9 accepted irq before end", irq_n, 1);
        @(negedge clk);
        chk("R9 accepted at boundary", irq_n, 0);
        exp = {hpat(r - 1), lpat(r + L - 1)};
        rd_n = 1'b0;
        #1;
        chk("R4 result after wake", bus_dat, exp);
        @(negedge clk);
        rd_n = 1'b1;
        cs_n = 1'b1;
        d_last = r + L;
        last_byte = exp;
        @(negedge clk);

        // constrained random mix
        for (int i = 0; i < 24; i++) begin
            logic m;
            m = 1'($urandom_range(0, 1));
            if (m != mode_sel) begin
                mode_sel = m;
                @(negedge clk);
            end
            repeat ($urandom_range(0, 5)) @(negedge clk);
            if (m) wr_conv(int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)));
            else   read_conv();
        end

        summary();
        $finish;
    end

endmodule